// File: doc/BRIEF.md
# Live Trigger Latch with Multi-Source Busy

This block sits between the trigger selection logic and the digitizer gate drivers of a readout system. It takes raw trigger pulses and turns each accepted one into a single live trigger. The live trigger then stays high until every readout system has finished, so the same signal serves as a global busy. A raw trigger is accepted only when the run enable is high and none of the busy inputs is asserted. After a fixed arming delay the live latch is set. It is released by the falling edge of the OR of all busy inputs, or by a clear-busy pulse.

Each accepted trigger fires three gate outputs of programmable width: the converter gate, the time-to-digital start and the coincidence-register gate. The charge gate does not wait for acceptance. It opens directly on the rising edge of the primary detector signal, which avoids long analog delays upstream. If no trigger is accepted while the charge gate is open, a one-cycle fast-clear pulse follows the gate so that the charge converter can be discarded.

Live FSM states: `LV_IDLE` moves to `LV_ARM` on *accept*. `LV_ARM` moves to `LV_HOLD` on *arm_done*. `LV_HOLD` moves to `LV_IDLE` on *busy_fall* or *clear*. Charge FSM states: `CG_IDLE` moves to `CG_OPEN` on *prim_edge*. `CG_OPEN` moves to `CG_IDLE` on *gate_end_hit*, or to `CG_FCLR` on *gate_end_miss*. `CG_FCLR` returns to `CG_IDLE` after one cycle. Gate FSM states: `PG_IDLE` moves to `PG_ON` on *fire*, and `PG_ON` returns to `PG_IDLE` on *expire*.

Top module: `trig_live_latch`

## Requirements
- R1: Every input passes through a two-flop synchronizer. A rising edge on `raw_trig`, driven just after a clock edge, raises `live` exactly 3 + ARM_CYC rising edges later. ARM_CYC defaults to 10, which is 50 ns at 200 MHz.
- R2: Once `live` is set it stays high while any bit of `busy_in` is high. It falls within two edges of the synchronized OR of `busy_in` going from 1 to 0, so it spans the longest busy.
- R3: A raw trigger edge that arrives while any busy input is high is not accepted. `live` stays low and no converter, TDC or coincidence gate is produced.
- R4: While `run_en` is low, raw trigger edges produce no `live`, and primary-source edges produce no charge gate and no fast clear.
- R5: If no busy input rises after acceptance, `live` stays high until `clr_busy` is pulsed. It then drops within three edges.
- R6: Raw trigger edges during arming or while `live` is high are ignored. They produce no extra gate and no new `live` after the release.
- R7: For each accepted trigger, `adc_gate`, `tdc_start` and `creg_gate` are each high for exactly their width input in cycles (0 to 255). A width of 0 gives no pulse.
- R8: A primary-source rising edge with `run_en` high opens `chg_gate` for exactly `chg_width` cycles, whether or not a trigger is accepted. A width of 0 gives no gate.
- R9: `fast_clear` is high for exactly one cycle, right after `chg_gate` closes, if no trigger was accepted while the gate was open. Otherwise it stays low.
- R10: While reset is held and right after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_trig | input | 1 | Raw trigger from source selection |
| prim_src | input | 1 | Primary detector signal for the charge gate |
| busy_in | input | NBUSY (7) | Busy levels from the readout systems |
| clr_busy | input | 1 | Manual release of the live latch |
| run_en | input | 1 | Run enable; low suppresses all triggers |
| adc_width | input | 8 | Converter gate width in cycles |
| tdc_width | input | 8 | TDC start width in cycles |
| creg_width | input | 8 | Coincidence-register gate width in cycles |
| chg_width | input | 8 | Charge gate width in cycles |
| live | output | 1 | Live trigger, doubling as global busy |
| adc_gate | output | 1 | Converter gate |
| tdc_start | output | 1 | TDC start |
| creg_gate | output | 1 | Coincidence-register gate |
| chg_gate | output | 1 | Charge gate |
| fast_clear | output | 1 | Discard pulse for the charge converter |

## Verification
Random events mix four cases: raw trigger with a primary pulse, raw trigger alone, primary pulse alone, and raw trigger with random busy subsets of staggered length. This separates a latch that follows the longest busy from one that follows the first busy or the first fall, and it separates charge gates that saw acceptance from those that must end in a fast clear. Directed cases apply a trigger under an asserted busy, a trigger and a primary pulse with the run enable low, a latch with no busy at all that only the clear input releases, and a retrigger while held. Together these cover veto, suppression, manual release and retrigger immunity. Zero and random widths show that each gate length follows its own width input.

// File: rtl/tll_pkg.sv
package tll_pkg;

    typedef enum logic [1:0] {
        LV_IDLE = 2'd0,
        LV_ARM  = 2'd1,
        LV_HOLD = 2'd2
    } live_st_t;

    typedef enum logic [1:0] {
        CG_IDLE = 2'd0,
        CG_OPEN = 2'd1,
        CG_FCLR = 2'd2
    } chg_st_t;

    typedef enum logic {
        PG_IDLE = 1'b0,
        PG_ON   = 1'b1
    } pg_st_t;

endpackage

// File: rtl/tll_sync.sv
module tll_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/tll_gate_gen.sv
module tll_gate_gen
    import tll_pkg::*;
#(
    parameter int WW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [WW-1:0] width,
    output logic          gate
);

    pg_st_t        state_q, state_d;
    logic [WW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PG_IDLE: begin
                if (start && (width != '0)) begin
                    state_d = PG_ON;
                    cnt_d   = width;
                end
            end
            PG_ON: begin
                if (cnt_q == WW'(1)) begin
                    state_d = PG_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        gate = (state_q == PG_ON);
    end

    // R7
    gate_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> $past(start));

    // R7
    zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (width == '0) && !gate) |=> !gate);

endmodule

// File: rtl/tll_charge_fc.sv
module tll_charge_fc
    import tll_pkg::*;
#(
    parameter int WW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prim_rise,
    input  logic          run_en,
    input  logic          accept,
    input  logic [WW-1:0] width,
    output logic          gate,
    output logic          fast_clear
);

    chg_st_t       state_q, state_d;
    logic [WW-1:0] cnt_q, cnt_d;
    logic          seen_q, seen_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        seen_d  = seen_q;
        unique case (state_q)
            CG_IDLE: begin
                if (prim_rise && run_en && (width != '0)) begin
                    state_d = CG_OPEN;
                    cnt_d   = width;
                    seen_d  = accept;
                end
            end
            CG_OPEN: begin
                seen_d = seen_q | accept;
                if (cnt_q == WW'(1)) begin
                    state_d = (seen_q | accept) ? CG_IDLE : CG_FCLR;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            CG_FCLR: state_d = CG_IDLE;
            default: state_d = CG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CG_IDLE;
            cnt_q   <= '0;
            seen_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            seen_q  <= seen_d;
        end
    end

    always_comb begin
        gate       = (state_q == CG_OPEN);
        fast_clear = (state_q == CG_FCLR);
    end

    // R9
    fc_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_clear |-> $fell(gate));

    // R9
    fc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_clear |=> !fast_clear);

    // R4
    chg_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !fast_clear && !run_en) |=> !gate);

endmodule

// File: rtl/tll_live_fsm.sv
module tll_live_fsm
    import tll_pkg::*;
#(
    parameter int ARM_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_rise,
    input  logic busy_any,
    input  logic run_en,
    input  logic clr_busy,
    output logic accept,
    output logic enter_live,
    output logic live
);

    localparam int CW = (ARM_CYC > 1) ? $clog2(ARM_CYC) : 1;

    live_st_t      state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          busy_prev_q;
    logic          busy_fall;

    always_comb begin
        busy_fall = busy_prev_q && !busy_any;
    end

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        accept     = 1'b0;
        enter_live = 1'b0;
        unique case (state_q)
            LV_IDLE: begin
                if (raw_rise && !busy_any && run_en) begin
                    accept  = 1'b1;
                    state_d = LV_ARM;
                    cnt_d   = CW'(ARM_CYC - 1);
                end
            end
            LV_ARM: begin
                if (cnt_q == '0) begin
                    state_d    = LV_HOLD;
                    enter_live = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            LV_HOLD: begin
                if (clr_busy || busy_fall) begin
                    state_d = LV_IDLE;
                end
            end
            default: state_d = LV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= LV_IDLE;
            cnt_q       <= '0;
            busy_prev_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            cnt_q       <= cnt_d;
            busy_prev_q <= busy_any;
        end
    end

    always_comb begin
        live = (state_q == LV_HOLD);
    end

    // R3
    busy_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == LV_IDLE) && busy_any) |=> (state_q == LV_IDLE));

    // R4
    run_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == LV_IDLE) && !run_en) |=> (state_q == LV_IDLE));

    // R2
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && busy_any && !clr_busy) |=> live);

    // R5
    clr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && clr_busy) |=> !live);

    // R6
    arm_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_ARM) |=> (state_q != LV_IDLE));

endmodule

// File: rtl/trig_live_latch.sv
module trig_live_latch #(
    parameter int NBUSY   = 7,
    parameter int WW      = 8,
    parameter int ARM_CYC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_trig,
    input  logic             prim_src,
    input  logic [NBUSY-1:0] busy_in,
    input  logic             clr_busy,
    input  logic             run_en,
    input  logic [WW-1:0]    adc_width,
    input  logic [WW-1:0]    tdc_width,
    input  logic [WW-1:0]    creg_width,
    input  logic [WW-1:0]    chg_width,
    output logic             live,
    output logic             adc_gate,
    output logic             tdc_start,
    output logic             creg_gate,
    output logic             chg_gate,
    output logic             fast_clear
);

    localparam int NIN = NBUSY + 4;
    localparam int NG  = 3;

    logic [NIN-1:0]   sync_d, sync_q;
    logic [NBUSY-1:0] busy_s;
    logic             raw_s, prim_s, clr_s, run_s;
    logic             raw_prev_q, prim_prev_q;
    logic             raw_rise, prim_rise, busy_any;
    logic             accept, enter_live;
    logic [WW-1:0]    width_arr [NG];
    logic [NG-1:0]    gate_vec;

    always_comb begin
        sync_d = {run_en, clr_busy, prim_src, raw_trig, busy_in};
    end

    tll_sync #(.W(NIN)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_d),
        .q     (sync_q)
    );

    always_comb begin
        busy_s    = sync_q[NBUSY-1:0];
        raw_s     = sync_q[NBUSY];
        prim_s    = sync_q[NBUSY+1];
        clr_s     = sync_q[NBUSY+2];
        run_s     = sync_q[NBUSY+3];
        busy_any  = |busy_s;
        raw_rise  = raw_s && !raw_prev_q;
        prim_rise = prim_s && !prim_prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_prev_q  <= 1'b0;
            prim_prev_q <= 1'b0;
        end else begin
            raw_prev_q  <= raw_s;
            prim_prev_q <= prim_s;
        end
    end

    tll_live_fsm #(.ARM_CYC(ARM_CYC)) live_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_rise   (raw_rise),
        .busy_any   (busy_any),
        .run_en     (run_s),
        .clr_busy   (clr_s),
        .accept     (accept),
        .enter_live (enter_live),
        .live       (live)
    );

    always_comb begin
        width_arr[0] = adc_width;
        width_arr[1] = tdc_width;
        width_arr[2] = creg_width;
    end

    for (genvar g = 0; g < NG; g++) begin : g_gate
        tll_gate_gen #(.WW(WW)) gen_i (
            .clk   (clk),
            .rst_n (rst_n),
            .start (enter_live),
            .width (width_arr[g]),
            .gate  (gate_vec[g])
        );
    end

    always_comb begin
        adc_gate  = gate_vec[0];
        tdc_start = gate_vec[1];
        creg_gate = gate_vec[2];
    end

    tll_charge_fc #(.WW(WW)) chg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .prim_rise  (prim_rise),
        .run_en     (run_s),
        .accept     (accept),
        .width      (chg_width),
        .gate       (chg_gate),
        .fast_clear (fast_clear)
    );

    // R1
    gates_need_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(adc_gate) || $rose(tdc_start) || $rose(creg_gate)) |-> $rose(live));

endmodule

// File: tb/trig_live_latch_tb_top.sv
`timescale 1ns/1ps
module trig_live_latch_tb_top;

    localparam int NBUSY   = 7;
    localparam int ARM_CYC = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             raw_trig = 1'b0;
    logic             prim_src = 1'b0;
    logic [NBUSY-1:0] busy_in = '0;
    logic             clr_busy = 1'b0;
    logic             run_en = 1'b1;
    logic [7:0]       adc_width = 8'd0;
    logic [7:0]       tdc_width = 8'd0;
    logic [7:0]       creg_width = 8'd0;
    logic [7:0]       chg_width = 8'd0;
    logic             live, adc_gate, tdc_start, creg_gate, chg_gate, fast_clear;

    int n_cmp = 0;
    int n_bad = 0;
    int c_adc, c_tdc, c_creg, c_chg, c_fc;

    always #2.5 clk = ~clk;

    trig_live_latch #(.NBUSY(NBUSY), .WW(8), .ARM_CYC(ARM_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .raw_trig(raw_trig), .prim_src(prim_src),
        .busy_in(busy_in), .clr_busy(clr_busy), .run_en(run_en),
        .adc_width(adc_width), .tdc_width(tdc_width), .creg_width(creg_width),
        .chg_width(chg_width), .live(live), .adc_gate(adc_gate),
        .tdc_start(tdc_start), .creg_gate(creg_gate), .chg_gate(chg_gate),
        .fast_clear(fast_clear)
    );

    always @(posedge clk) begin
        #2;
        if (adc_gate)   c_adc++;
        if (tdc_start)  c_tdc++;
        if (creg_gate)  c_creg++;
        if (chg_gate)   c_chg++;
        if (fast_clear) c_fc++;
    end

    function automatic int exp_latency();
        return 3 + ARM_CYC;
    endfunction

    function automatic int exp_gate(int w, bit acc);
        return acc ? w : 0;
    endfunction

    function automatic int exp_fc(int cw, bit prim, bit acc, bit run);
        return (prim && run && (cw != 0) && !acc) ? 1 : 0;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic zero_counts();
        c_adc = 0; c_tdc = 0; c_creg = 0; c_chg = 0; c_fc = 0;
    endtask

    task automatic wait_neg(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_widths(int a, int t, int c, int q);
        adc_width = 8'(a); tdc_width = 8'(t); creg_width = 8'(c); chg_width = 8'(q);
    endtask

    task automatic check_gates(string tag, bit acc, bit prim);
        chk("R7", {tag, " adc cycles"},  c_adc,  exp_gate(adc_width, acc));
        chk("R7", {tag, " tdc cycles"},  c_tdc,  exp_gate(tdc_width, acc));
        chk("R7", {tag, " creg cycles"}, c_creg, exp_gate(creg_width, acc));
        chk("R8", {tag, " chg cycles"},  c_chg,  prim ? int'(chg_width) : 0);
        chk("R9", {tag, " fast clear"},  c_fc,   exp_fc(chg_width, prim, acc, 1'b1));
    endtask

    task automatic run_event(bit with_raw, bit with_prim);
        int lat;
        int lens [NBUSY];
        int maxlen;
        int held_bad;
        logic [NBUSY-1:0] mask;
        @(negedge clk);
        zero_counts();
        prim_src = with_prim;
        raw_trig = with_raw;
        if (with_raw) begin
            lat = 0;
            while (lat < 40) begin
                @(posedge clk);
                lat++;
                #1;
                if (live) break;
            end
            chk("R1", "live latency", lat, exp_latency());
            @(negedge clk);
            raw_trig = 1'b0;
            prim_src = 1'b0;
            mask = NBUSY'($urandom_range(1, (1 << NBUSY) - 1));
            maxlen = 0;
            for (int i = 0; i < NBUSY; i++) begin
                lens[i] = mask[i] ? int'($urandom_range(1, 30)) : 0;
                if (lens[i] > maxlen) maxlen = lens[i];
            end
            held_bad = 0;
            for (int t = 0; t <= maxlen; t++) begin
                if (t > 0) @(negedge clk);
                if (!live) held_bad++;
                for (int i = 0; i < NBUSY; i++) busy_in[i] = (t < lens[i]);
            end
            chk("R2", "live held to longest busy", held_bad, 0);
            wait_neg(5);
            chk("R2", "live released after busy fall", int'(live), 0);
        end else begin
            wait_neg(3);
            prim_src = 1'b0;
        end
        wait_neg(120);
        check_gates(with_raw ? "trig" : "prim-only", with_raw, with_prim);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20251));
        wait_neg(3);
        // R10 outputs during reset
        chk("R10", "outputs in reset",
            int'({live, adc_gate, tdc_start, creg_gate, chg_gate, fast_clear}), 0);
        rst_n = 1'b1;
        wait_neg(4);
        chk("R10", "outputs after reset",
            int'({live, adc_gate, tdc_start, creg_gate, chg_gate, fast_clear}), 0);

        // R7 directed zero width on two gates
        set_widths(0, 0, 1, 9);
        run_event(1'b1, 1'b1);

        // R9 directed: primary only, fast clear expected
        set_widths(5, 5, 5, 12);
        run_event(1'b0, 1'b1);

        // R3 veto by an asserted busy
        @(negedge clk);
        zero_counts();
        set_widths(6, 6, 6, 7);
        busy_in = 7'b0001000;
        wait_neg(5);
        raw_trig = 1'b1; prim_src = 1'b1;
        wait_neg(3);
        raw_trig = 1'b0; prim_src = 1'b0;
        wait_neg(40);
        chk("R3", "live under busy", int'(live), 0);
        chk("R3", "adc under busy", c_adc, 0);
        chk("R9", "fast clear after vetoed trigger", c_fc, 1);
        busy_in = '0;
        wait_neg(10);
        chk("R3", "live after idle busy fall", int'(live), 0);

        // R4 run enable low
        @(negedge clk);
        zero_counts();
        run_en = 1'b0;
        wait_neg(5);
        raw_trig = 1'b1; prim_src = 1'b1;
        wait_neg(3);
        raw_trig = 1'b0; prim_src = 1'b0;
        wait_neg(40);
        chk("R4", "live with run off", int'(live), 0);
        chk("R4", "charge gate with run off", c_chg, 0);
        chk("R4", "fast clear with run off", c_fc, 0);
        run_en = 1'b1;
        wait_neg(5);

        // R5 / R6 latch without busy, retrigger, manual clear
        @(negedge clk);
        zero_counts();
        set_widths(4, 3, 2, 0);
        raw_trig = 1'b1;
        wait_neg(20);
        raw_trig = 1'b0;
        wait_neg(40);
        chk("R5", "latch held without busy", int'(live), 1);
        raw_trig = 1'b1;
        wait_neg(3);
        raw_trig = 1'b0;
        wait_neg(20);
        chk("R6", "live during retrigger", int'(live), 1);
        clr_busy = 1'b1;
        wait_neg(2);
        clr_busy = 1'b0;
        wait_neg(3);
        chk("R5", "live after clear", int'(live), 0);
        wait_neg(30);
        chk("R6", "no relatch after clear", int'(live), 0);
        chk("R6", "adc single pulse", c_adc, 4);
        chk("R6", "tdc single pulse", c_tdc, 3);

        // random events
        for (int k = 0; k < 14; k++) begin
            bit wr, wp;
            wr = 1'($urandom_range(0, 3) != 0);
            wp = wr ? 1'($urandom_range(0, 1)) : 1'b1;
            set_widths($urandom_range(0, 60), $urandom_range(0, 60),
                       $urandom_range(0, 60), $urandom_range(1, 40));
            run_event(wr, wp);
        end

        finish_run();
    end

endmodule